// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block produces the serial bit clock and the frame-sync strobe for a PCM audio port. It runs entirely in one clock domain (`clk_i`). The source for the divider is a stream of tick enables. When the bus clock is selected, every `clk_i` cycle is a tick. When the alternate audio clock is selected, only cycles with `aud_tick_i` high are ticks. Muxing between truly asynchronous clocks is not part of this block.

A 20-bit control word sets four things: the enable, the source select, a half-period divider N and a frame divider M. The bit clock toggles every N+1 ticks. A frame is M+1 bit-clock periods long. Frame sync is high for the whole first bit period of each frame. The block also gives the serializer and deserializer a one-cycle rising-edge strobe and a one-cycle falling-edge strobe. It takes new divider values only at frame boundaries. When it is disabled, it finishes the bit period in progress and then stops.

Top module: `pcm_clk_gen`

## Requirements
- R1: While `rst_ni` is low and after its release, `bclk_o`, `fsync_o`, `bclk_rise_o` and `bclk_fall_o` are all low until the generator is enabled.
- R2: Bit 19 of `ctl_i` enables the generator. While it is clear and the generator is stopped, `bclk_o` and `fsync_o` stay low and no edge strobe fires.
- R3: Bit 18 of `ctl_i` selects the tick source. When it is 1, every `clk_i` cycle is a tick. When it is 0, only cycles with `aud_tick_i` high are ticks.
- R4: The generator starts on the first clock edge at which the enable is seen. From that edge, `bclk_o` rises after N+1 ticks and then toggles every N+1 ticks. N is `ctl_i[17:9]`, so the bit period is 2·(N+1) ticks.
- R5: A frame lasts M+1 bit periods, where M is `ctl_i[8:0]`. A bit period begins low and ends at a falling edge of `bclk_o`. `fsync_o` rises on the edge that starts bit 0 of a frame and falls on the falling edge of `bclk_o` that ends bit 0.
- R6: `bclk_rise_o` is high for exactly the one `clk_i` cycle in which `bclk_o` has just turned high. `bclk_fall_o` is high for exactly the one cycle in which `bclk_o` has just turned low.
- R7: Changes to N or M while the generator runs take effect only from the next frame boundary. The frame in progress keeps its length and bit period.
- R8: When the enable is cleared, the current bit period completes and then all outputs stay low. A new enable restarts the sequence at bit 0 with frame sync high.
- R9: With N = 0, `bclk_o` toggles on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; with bus source selected, each cycle is a tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 20 | Control word: [19] enable, [18] source select, [17:9] N, [8:0] M |
| aud_tick_i | input | 1 | Tick enable from the alternate audio clock |
| bclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame sync, high for bit 0 of every frame |
| bclk_rise_o | output | 1 | One-cycle strobe on each bit-clock rising edge |
| bclk_fall_o | output | 1 | One-cycle strobe on each bit-clock falling edge |

## Verification
The bench predicts the exact clock edge of every bit-clock edge and every frame-sync edge, so any off-by-one in the half-period count is caught. Such an error would shift every later edge by whole ticks. The bench rewrites N and M early in a frame. A design that applied them at once would shorten that frame and put the next frame-sync edge at the wrong time. The bench also clears the enable in the middle of a bit. A design that stopped at once, or one that ran on to the end of the frame, would produce a truncated or extra edge. Further cases cover N = 0, where the bit clock toggles on every tick, and the sparse alternate tick source, where a divider that counted `clk_i` cycles instead of ticks would run about three times too fast.

// File: rtl/pcm_clk_pkg.sv
package pcm_clk_pkg;
  localparam int DIV_W = 9;
  localparam int CTL_W = 2 + 2 * DIV_W;

  // bit order is fixed: [19] enable, [18] bus source, [17:9] half div, [8:0] frame div
  typedef struct packed {
    logic             en;
    logic             sel_bus;
    logic [DIV_W-1:0] half_div;
    logic [DIV_W-1:0] frame_div;
  } clk_ctl_t;
endpackage

// File: rtl/pcm_clk_src_sel.sv
module pcm_clk_src_sel (
  input  logic sel_bus_i,
  input  logic aud_tick_i,
  output logic tick_o
);
  assign tick_o = sel_bus_i | aud_tick_i;
endmodule

// File: rtl/pcm_clk_half_div.sv
module pcm_clk_half_div #(
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] n_i,
  output logic             fall_evt_o,
  output logic             bclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap       = run_i & tick_i & (cnt_q == n_i);
  assign fall_evt_o = wrap & bclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (!run_i) begin
        cnt_q  <= '0;
        bclk_o <= 1'b0;
      end else if (tick_i) begin
        if (wrap) begin
          cnt_q  <= '0;
          bclk_o <= ~bclk_o;
          rise_o <= ~bclk_o;
          fall_o <= bclk_o;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R6
  AST_RISE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (bclk_o && !$past(bclk_o))); // R6
  AST_FALL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!bclk_o && $past(bclk_o))); // R6
  AST_HALF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= n_i); // R4
endmodule

// File: rtl/pcm_clk_frame_ctr.sv
module pcm_clk_frame_ctr #(
  parameter int                DIV_W    = 9,
  parameter logic [DIV_W-1:0] SYNC_RST = 9'd127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] n_i,
  input  logic [DIV_W-1:0] m_i,
  input  logic             fall_evt_i,
  output logic             run_o,
  output logic [DIV_W-1:0] n_o,
  output logic             fsync_o
);
  logic [DIV_W-1:0] bit_q, m_q;

  assign fsync_o = run_o & (bit_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0;
      bit_q <= '0;
      n_o   <= '0;
      m_q   <= SYNC_RST;
    end else if (!run_o) begin
      bit_q <= '0;
      if (en_i) begin
        run_o <= 1'b1;
        n_o   <= n_i;
        m_q   <= m_i;
      end
    end else if (fall_evt_i) begin
      if (!en_i) begin
        run_o <= 1'b0;
        bit_q <= '0;
      end else if (bit_q == m_q) begin
        bit_q <= '0;
        n_o   <= n_i;
        m_q   <= m_i;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !fall_evt_i) |=> $stable({n_o, m_q})); // R7
  AST_STOP_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> $past(fall_evt_i)); // R8
  AST_BIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= m_q); // R5
endmodule

// File: rtl/pcm_clk_gen.sv
module pcm_clk_gen
  import pcm_clk_pkg::*;
#(
  parameter logic [DIV_W-1:0] SYNC_RST = 9'd127
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             aud_tick_i,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic             bclk_rise_o,
  output logic             bclk_fall_o
);
  clk_ctl_t         ctl;
  logic             tick, run, fall_evt;
  logic [DIV_W-1:0] n_act;

  assign ctl = clk_ctl_t'(ctl_i);

  pcm_clk_src_sel u_src (
    .sel_bus_i  (ctl.sel_bus),
    .aud_tick_i (aud_tick_i),
    .tick_o     (tick)
  );

  pcm_clk_frame_ctr #(.DIV_W(DIV_W), .SYNC_RST(SYNC_RST)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctl.en),
    .n_i        (ctl.half_div),
    .m_i        (ctl.frame_div),
    .fall_evt_i (fall_evt),
    .run_o      (run),
    .n_o        (n_act),
    .fsync_o    (fsync_o)
  );

  pcm_clk_half_div #(.DIV_W(DIV_W)) u_half (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .n_i        (n_act),
    .fall_evt_o (fall_evt),
    .bclk_o     (bclk_o),
    .rise_o     (bclk_rise_o),
    .fall_o     (bclk_fall_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!bclk_o && !fsync_o && !bclk_rise_o)); // R2
endmodule

// File: tb/pcm_clk_gen_test.sv
`timescale 1ns/1ps
module pcm_clk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] ctl_r = '0;
  logic        aud_tick = 1'b0;
  logic        bclk, fsync, rise, fall;
  int          cyc = 0;
  int          n_checks = 0;
  int          n_fails = 0;
  bit          done = 1'b0;
  bit          fs_prev = 1'b0;

  typedef struct {
    int    at;
    int    kind; // 0 rise, 1 fall, 2 fsync rise, 3 fsync fall
    string tag;
  } evt_t;
  evt_t exp_q[$];

  pcm_clk_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctl_i       (ctl_r),
    .aud_tick_i  (aud_tick),
    .bclk_o      (bclk),
    .fsync_o     (fsync),
    .bclk_rise_o (rise),
    .bclk_fall_o (fall)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) aud_tick <= ((cyc + 1) % 3 == 0);

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_evt(input int kind);
    evt_t e;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_fails++;
      $display("FAIL R2 unexpected event kind=%0d at %0d actual=event expected=none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_fails++;
        $display("FAIL %s event actual=kind%0d@%0d expected=kind%0d@%0d",
                 e.tag, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rise) check_evt(0);
      if (fall) check_evt(1);
      if (fs_prev && !fsync) check_evt(3);
      if (!fs_prev && fsync) check_evt(2);
    end
    fs_prev = fsync;
  end

  function automatic int nth_tick(input int t, input int k, input bit sel);
    int e = t;
    for (int i = 0; i < k; i++) begin
      e++;
      while (!(sel || (e % 3 == 0))) e++;
    end
    return e;
  endfunction

  task automatic push(input int at, input int kind, input string tag);
    evt_t e;
    e.at = at; e.kind = kind; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run_case(input int n1, input int m1, input int n2, input int m2,
                          input bit sel, input int nbits, input int chg_at,
                          input string tag);
    int t, cn, cm, bif, last_rise, e0;
    @(negedge clk);
    e0 = cyc + 1;
    ctl_r = {1'b1, sel, 9'(n1), 9'(m1)};
    t = e0; cn = n1; cm = m1; bif = 0;
    for (int b = 0; b < nbits; b++) begin
      if (bif == 0) push(t, 2, tag);
      last_rise = nth_tick(t, cn + 1, sel);
      push(last_rise, 0, tag);
      t = nth_tick(last_rise, cn + 1, sel);
      push(t, 1, tag);
      if (bif == 0) push(t, 3, tag);
      if (bif == cm) begin
        bif = 0; cn = n2; cm = m2;
      end else begin
        bif++;
      end
    end
    if (chg_at > 0) begin
      while (cyc < e0 + chg_at) @(negedge clk);
      ctl_r[17:0] = {9'(n2), 9'(m2)};
    end
    while (cyc < last_rise) @(negedge clk);
    ctl_r[19] = 1'b0;
    while (cyc < t + 4) @(negedge clk);
    check(!bclk && !fsync, {tag, " R8 idle after stop"}, int'({bclk, fsync}), 0);
    check(exp_q.size() == 0, {tag, " missing events"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bclk && !fsync && !rise && !fall, "R1 outputs in reset",
          int'({bclk, fsync, rise, fall}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bclk && !fsync && !rise && !fall, "R1 outputs after reset",
          int'({bclk, fsync, rise, fall}), 0);
    // disabled with nonzero dividers: nothing must move
    ctl_r = {1'b0, 1'b1, 9'd1, 9'd2};
    repeat (30) @(negedge clk);
    check(!bclk && !fsync, "R2 idle while disabled", int'({bclk, fsync}), 0);

    run_case(2, 3, 2, 3, 1'b1, 10, 0, "R4 R5 R6 R8");
    run_case(0, 1, 0, 1, 1'b1, 6, 0, "R9 R5");
    run_case(1, 2, 3, 4, 1'b1, 8, 3, "R7");
    run_case(1, 2, 1, 2, 1'b0, 7, 0, "R3");
    run_case(4, 2, 4, 2, 1'b1, 4, 0, "R8 restart");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule